// File: doc/BRIEF.md
# Dual-Personality Host Register Port

This block lets an 8-bit host processor read and write a 256-byte register array. Two static strap inputs pick one of four bus personalities: a separate or a shared address/data bus, and strobe timing in the style of either a read strobe plus write strobe or a data strobe plus read/write level. The same three control pins change meaning and polarity with the chosen personality. On a shared bus, the address is captured from the data lines when the latch pin rises. On a separate bus, that same latch pin becomes the top address bit.

All pins are sampled in the system clock domain. Writes take effect when the write qualifier ends. Read data is driven through an output enable. Two status registers collect one-cycle event pulses, and each is cleared by reading it. Two mask registers, which are ordinary array entries, gate the status bits onto an open-drain style interrupt. A test input releases every output.

Top module: `hbus_port`

## Requirements
- R1: With `mux_sel`=0, the register address is {`ale_a7`, `addr_lo[6:0]`}, so all 256 locations are reachable.
- R2: With `mux_sel`=1, the address is taken from `dbus_in` in the clock cycle where `ale_a7` is first sampled high after being low. `addr_lo` is ignored, and the latched address holds until the next rising edge of `ale_a7`.
- R3: With `moto_sel`=0, `rd_ds` low requests a read and `wr_rw` low requests a write.
- R4: With `moto_sel`=1, the data strobe on `rd_ds` is active high when `mux_sel`=0 and active low when `mux_sel`=1. While the strobe is active, `wr_rw`=1 means read and 0 means write.
- R5: While `cs_n` is high, no write changes any register and `dbus_oe` stays 0.
- R6: A write commits on the first clock where the write qualifier (chip select and write) is found inactive after being active. It uses the address and data sampled in the last active cycle. All 256 bytes reset to 0x00 under synchronous `rst`.
- R7: `dbus_oe` is 1 exactly while chip select and a read qualifier are active and `test_hiz` is 0. `dbus_out` then carries the addressed byte.
- R8: Status register k (k=0 at address 0x20, k=1 at 0x21) has bits set by the one-cycle pulses on `evt_a` (k=0) or `evt_b` (k=1).
- R9: A read of a status register clears, at its trailing edge, only the bits returned by that read. An event arriving during the read survives. Host writes to 0x20 and 0x21 are ignored.
- R10: `irq_drive` (1 = pull the interrupt line low) is 1 when any status bit is set together with its mask bit. The masks are at 0x22 for k=0 and 0x23 for k=1.
- R11: While `test_hiz` is 1, `dbus_oe` and `irq_drive` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mux_sel | input | 1 | Strap: 1 = shared address/data bus |
| moto_sel | input | 1 | Strap: 1 = data strobe plus read/write level timing |
| test_hiz | input | 1 | 1 = release all outputs |
| cs_n | input | 1 | Chip select, active low |
| rd_ds | input | 1 | Read strobe or data strobe |
| wr_rw | input | 1 | Write strobe or read/write level |
| ale_a7 | input | 1 | Address latch/strobe (shared) or address bit 7 (separate) |
| addr_lo | input | 7 | Address bits 6..0 (separate bus only) |
| dbus_in | input | 8 | Host data bus, received side |
| dbus_out | output | 8 | Host data bus, driven side |
| dbus_oe | output | 1 | Enable for driving `dbus_out` |
| evt_a | input | 8 | Event pulses for status register 0 |
| evt_b | input | 8 | Event pulses for status register 1 |
| irq_drive | output | 1 | 1 = pull the open-drain interrupt line low |

## Verification
A wrong latched address or strobe decode shows on the first read-back after a write: a byte lands in or is read from the wrong location. The sweep over every address in all four personalities exposes this within one access. A status clear that is too broad loses an event that arrived mid-read, and this shows on the next read of that register. A wrong mask path shows on `irq_drive` one clock after the event or mask write. A test-mode leak shows on `dbus_oe` or `irq_drive` in the very cycle `test_hiz` rises.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int DW  = 8;
    localparam int AW  = 8;
    localparam int NST = 2;

    typedef enum logic [1:0] {
        PER_RW_SEP  = 2'b00,
        PER_RW_MUX  = 2'b01,
        PER_DS_SEP  = 2'b10,
        PER_DS_MUX  = 2'b11
    } persona_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } strobe_t;

    function automatic persona_e pick_persona(logic moto, logic mux);
        return persona_e'({moto, mux});
    endfunction

    // Turns the raw control pins into read and write requests.
    function automatic strobe_t decode_strobes(persona_e p, logic rd_ds, logic wr_rw);
        strobe_t s;
        logic    ds;
        ds = 1'b0;
        s  = '0;
        case (p)
            PER_RW_SEP, PER_RW_MUX: begin
                s.rd = ~rd_ds;
                s.wr = ~wr_rw;
            end
            PER_DS_SEP: ds = rd_ds;
            default:    ds = ~rd_ds;
        endcase
        if (p == PER_DS_SEP || p == PER_DS_MUX) begin
            s.rd = ds & wr_rw;
            s.wr = ds & ~wr_rw;
        end
        return s;
    endfunction

endpackage

// File: rtl/hbus_decode.sv
module hbus_decode
    import hbus_pkg::*;
(
    input  logic    mux_sel,
    input  logic    moto_sel,
    input  logic    cs_n,
    input  logic    rd_ds,
    input  logic    wr_rw,
    output strobe_t req
);
    strobe_t raw;

    always_comb begin
        raw = decode_strobes(pick_persona(moto_sel, mux_sel), rd_ds, wr_rw);
        req.rd = raw.rd & ~cs_n;
        req.wr = raw.wr & ~cs_n;
    end
endmodule

// File: rtl/hbus_addr_latch.sv
module hbus_addr_latch #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mux_sel,
    input  logic          ale_a7,
    input  logic [AW-2:0] addr_lo,
    input  logic [AW-1:0] dbus_in,
    output logic [AW-1:0] addr
);
    logic          ale_q;
    logic [AW-1:0] lat_q;
    logic          take;

    assign take = mux_sel & ale_a7 & ~ale_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ale_q <= 1'b0;
            lat_q <= '0;
        end else begin
            ale_q <= ale_a7;
            if (take) lat_q <= dbus_in;
        end
    end

    assign addr = mux_sel ? lat_q : {ale_a7, addr_lo};

    AST_LATCH_TAKES_BUS: assert property (@(posedge clk) disable iff (rst)
        (mux_sel && ale_a7 && !ale_q) |=> (lat_q == $past(dbus_in))); // R2
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!ale_a7 || ale_q || !mux_sel) |=> $stable(lat_q)); // R2
endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
    parameter int               AW        = 8,
    parameter int               DW        = 8,
    parameter int               NST       = 2,
    parameter logic [AW-1:0]    ST_BASE   = 8'h20,
    parameter logic [AW-1:0]    MASK_BASE = 8'h22
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_req,
    input  logic [AW-1:0]           addr,
    input  logic [DW-1:0]           dbus_in,
    output logic [DW-1:0]           rd_data,
    output logic [NST-1:0][DW-1:0]  masks
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic          wr_q;
    logic [AW-1:0] wa_q;
    logic [DW-1:0] wd_q;
    logic          commit;
    logic          wa_is_status;

    assign commit       = wr_q & ~wr_req;
    assign wa_is_status = (wa_q >= ST_BASE) && (wa_q < ST_BASE + AW'(NST));

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q <= 1'b0;
            wa_q <= '0;
            wd_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            wr_q <= wr_req;
            if (wr_req) begin
                wa_q <= addr;
                wd_q <= dbus_in;
            end
            if (commit && !wa_is_status) mem[wa_q] <= wd_q;
        end
    end

    assign rd_data = mem[addr];

    for (genvar k = 0; k < NST; k++) begin : g_mask
        assign masks[k] = mem[MASK_BASE + AW'(k)];
        AST_MASK_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (rst)
            !$stable(masks[k]) |-> $past(wr_q && !wr_req)); // R6
    end
endmodule

// File: rtl/hbus_status.sv
module hbus_status #(
    parameter int            AW      = 8,
    parameter int            DW      = 8,
    parameter int            NST     = 2,
    parameter logic [AW-1:0] ST_BASE = 8'h20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_req,
    input  logic [AW-1:0]           addr,
    input  logic [NST-1:0][DW-1:0]  evt,
    output logic [NST-1:0][DW-1:0]  st
);
    logic          rd_q;
    logic [AW-1:0] ra_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= 1'b0;
            ra_q <= '0;
        end else begin
            rd_q <= rd_req;
            if (rd_req) ra_q <= addr;
        end
    end

    for (genvar k = 0; k < NST; k++) begin : g_st
        localparam logic [AW-1:0] MY_ADDR = ST_BASE + AW'(k);
        logic [DW-1:0] snap;
        logic          clr;

        assign clr = rd_q & ~rd_req & (ra_q == MY_ADDR);

        always_ff @(posedge clk) begin
            if (rst) begin
                st[k] <= '0;
                snap  <= '0;
            end else begin
                if (rd_req && addr == MY_ADDR) snap <= st[k];
                st[k] <= (clr ? (st[k] & ~snap) : st[k]) | evt[k];
            end
        end

        AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
            (evt[k] != '0) |=> ((st[k] & $past(evt[k])) == $past(evt[k]))); // R8
        AST_STATUS_QUIET: assert property (@(posedge clk) disable iff (rst)
            (evt[k] == '0 && !clr) |=> $stable(st[k])); // R9
    end
endmodule

// File: rtl/hbus_port.sv
module hbus_port
    import hbus_pkg::*;
#(
    parameter logic [AW-1:0] ST_BASE   = 8'h20,
    parameter logic [AW-1:0] MASK_BASE = 8'h22
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mux_sel,
    input  logic          moto_sel,
    input  logic          test_hiz,
    input  logic          cs_n,
    input  logic          rd_ds,
    input  logic          wr_rw,
    input  logic          ale_a7,
    input  logic [AW-2:0] addr_lo,
    input  logic [DW-1:0] dbus_in,
    output logic [DW-1:0] dbus_out,
    output logic          dbus_oe,
    input  logic [DW-1:0] evt_a,
    input  logic [DW-1:0] evt_b,
    output logic          irq_drive
);
    strobe_t                 req;
    logic [AW-1:0]           addr;
    logic [DW-1:0]           mem_data;
    logic [NST-1:0][DW-1:0]  masks;
    logic [NST-1:0][DW-1:0]  st;
    logic [NST-1:0][DW-1:0]  evt;
    logic                    addr_is_status;
    logic [$clog2(NST)-1:0]  st_idx;

    assign evt = {evt_b, evt_a};

    hbus_decode u_decode (
        .mux_sel (mux_sel),
        .moto_sel(moto_sel),
        .cs_n    (cs_n),
        .rd_ds   (rd_ds),
        .wr_rw   (wr_rw),
        .req     (req)
    );

    hbus_addr_latch #(.AW(AW)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .mux_sel(mux_sel),
        .ale_a7 (ale_a7),
        .addr_lo(addr_lo),
        .dbus_in(dbus_in),
        .addr   (addr)
    );

    hbus_regfile #(.AW(AW), .DW(DW), .NST(NST), .ST_BASE(ST_BASE), .MASK_BASE(MASK_BASE)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_req (req.wr),
        .addr   (addr),
        .dbus_in(dbus_in),
        .rd_data(mem_data),
        .masks  (masks)
    );

    hbus_status #(.AW(AW), .DW(DW), .NST(NST), .ST_BASE(ST_BASE)) u_status (
        .clk   (clk),
        .rst   (rst),
        .rd_req(req.rd),
        .addr  (addr),
        .evt   (evt),
        .st    (st)
    );

    assign addr_is_status = (addr >= ST_BASE) && (addr < ST_BASE + AW'(NST));
    assign st_idx         = addr[$clog2(NST)-1:0] - ST_BASE[$clog2(NST)-1:0];

    always_comb begin
        dbus_out = addr_is_status ? st[st_idx] : mem_data;
        dbus_oe  = req.rd & ~test_hiz;
        irq_drive = 1'b0;
        for (int k = 0; k < NST; k++) irq_drive |= |(st[k] & masks[k]);
        irq_drive &= ~test_hiz;
    end

    AST_OE_GUARD: assert property (@(posedge clk) disable iff (rst)
        dbus_oe |-> (!cs_n && !test_hiz)); // R7
    AST_TEST_RELEASE: assert property (@(posedge clk) disable iff (rst)
        test_hiz |-> (!dbus_oe && !irq_drive)); // R11
    AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        irq_drive |-> ((st[0] & masks[0]) != '0 || (st[1] & masks[1]) != '0)); // R10
endmodule

// File: tb/hbus_port_tb.sv
module hbus_port_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mux_sel = 1'b0, moto_sel = 1'b0, test_hiz = 1'b0;
    logic       cs_n = 1'b1, rd_ds = 1'b1, wr_rw = 1'b1, ale_a7 = 1'b0;
    logic [6:0] addr_lo = '0;
    logic [7:0] dbus_in = '0, evt_a = '0, evt_b = '0;
    logic [7:0] dbus_out;
    logic       dbus_oe, irq_drive;

    int vectors = 0, bad = 0, cyc = 0;
    logic [7:0] model [256];
    logic [7:0] st_m [2];

    always #10 clk = ~clk;

    hbus_port u_dut (
        .clk(clk), .rst(rst), .mux_sel(mux_sel), .moto_sel(moto_sel), .test_hiz(test_hiz),
        .cs_n(cs_n), .rd_ds(rd_ds), .wr_rw(wr_rw), .ale_a7(ale_a7), .addr_lo(addr_lo),
        .dbus_in(dbus_in), .dbus_out(dbus_out), .dbus_oe(dbus_oe),
        .evt_a(evt_a), .evt_b(evt_b), .irq_drive(irq_drive)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Drives the control pins for the current personality.
    task automatic set_strobes(input logic rd_on, input logic wr_on);
        logic ds_on;
        if (!moto_sel) begin
            rd_ds = ~rd_on;
            wr_rw = ~wr_on;
        end else begin
            ds_on = rd_on | wr_on;
            rd_ds = mux_sel ? ~ds_on : ds_on;
            wr_rw = wr_on ? 1'b0 : 1'b1;
        end
    endtask

    task automatic set_mode(input logic moto, input logic mux);
        @(negedge clk);
        moto_sel = moto;
        mux_sel  = mux;
        cs_n     = 1'b1;
        ale_a7   = 1'b0;
        set_strobes(1'b0, 1'b0);
        @(negedge clk);
    endtask

    task automatic addr_phase(input logic [7:0] a);
        if (mux_sel) begin
            @(negedge clk);
            ale_a7  = 1'b1;
            dbus_in = a;
            addr_lo = ~a[6:0];
            @(negedge clk);
            ale_a7  = 1'b0;
            dbus_in = 8'h5A;
        end else begin
            ale_a7  = a[7];
            addr_lo = a[6:0];
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input logic sel);
        addr_phase(a);
        @(negedge clk);
        cs_n    = ~sel;
        dbus_in = d;
        set_strobes(1'b0, 1'b1);
        @(negedge clk);
        @(negedge clk);
        set_strobes(1'b0, 1'b0);
        @(negedge clk);
        cs_n = 1'b1;
        if (sel && !(a == 8'h20 || a == 8'h21)) model[a] = d;
    endtask

    task automatic bus_read(input logic [7:0] a, input string req, input logic [7:0] mid_a);
        logic [7:0] exp;
        logic [1:0] k;
        addr_phase(a);
        @(negedge clk);
        cs_n = 1'b0;
        set_strobes(1'b1, 1'b0);
        @(negedge clk);
        exp = (a == 8'h20) ? st_m[0] : (a == 8'h21) ? st_m[1] : model[a];
        chk(req, dbus_out, exp);
        chk("R7 oe during read", {7'd0, dbus_oe}, {7'd0, ~test_hiz});
        evt_a = mid_a;
        @(negedge clk);
        evt_a = '0;
        set_strobes(1'b0, 1'b0);
        if (a == 8'h20 || a == 8'h21) begin
            k = (a == 8'h20) ? 2'd0 : 2'd1;
            st_m[k[0]] = st_m[k[0]] & ~exp;
        end
        st_m[0] = st_m[0] | mid_a;
        @(negedge clk);
        cs_n = 1'b1;
        chk("R7 oe idle", {7'd0, dbus_oe}, 8'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) model[i] = '0;
        st_m[0] = '0;
        st_m[1] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R6 reset oe", {7'd0, dbus_oe}, 8'd0);
        chk("R10 reset irq", {7'd0, irq_drive}, 8'd0);
        bus_read(8'h55, "R6 reset content", 8'h00);

        // Every address, all four personalities.
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0]);
            for (int a = 0; a < 256; a++)
                bus_write(8'(a), 8'(a * 7 + m * 53 + 1), 1'b1);
            for (int a = 0; a < 256; a++)
                bus_read(8'(a), m[0] ? "R2 R3 R4 shared bus readback" : "R1 R3 R4 separate bus readback", 8'h00);
        end

        // Chip select held off.
        set_mode(1'b0, 1'b0);
        bus_write(8'h40, 8'hAA, 1'b0);
        bus_read(8'h40, "R5 write without cs", 8'h00);
        addr_phase(8'h40);
        @(negedge clk);
        set_strobes(1'b1, 1'b0);
        @(negedge clk);
        chk("R5 no drive without cs", {7'd0, dbus_oe}, 8'd0);
        set_strobes(1'b0, 1'b0);

        // Status and interrupt.
        bus_write(8'h22, 8'h00, 1'b1);
        bus_write(8'h23, 8'h00, 1'b1);
        @(negedge clk);
        evt_a = 8'h05;
        @(negedge clk);
        evt_a = 8'h00;
        st_m[0] = 8'h05;
        chk("R10 masked off", {7'd0, irq_drive}, 8'd0);
        bus_write(8'h22, 8'h04, 1'b1);
        chk("R10 mask enables irq", {7'd0, irq_drive}, 8'd1);
        bus_read(8'h20, "R8 status read", 8'h10);
        chk("R9 mid-read event kept, irq off", {7'd0, irq_drive}, 8'd0);
        bus_read(8'h20, "R9 survivor only", 8'h00);
        bus_read(8'h20, "R9 cleared", 8'h00);
        bus_write(8'h21, 8'hFF, 1'b1);
        bus_read(8'h21, "R9 status write ignored", 8'h00);

        @(negedge clk);
        evt_b = 8'h80;
        @(negedge clk);
        evt_b = 8'h00;
        st_m[1] = 8'h80;
        bus_write(8'h23, 8'h80, 1'b1);
        chk("R10 second register irq", {7'd0, irq_drive}, 8'd1);
        test_hiz = 1'b1;
        @(negedge clk);
        chk("R11 irq released", {7'd0, irq_drive}, 8'd0);
        bus_read(8'h21, "R11 read under test", 8'h00);
        test_hiz = 1'b0;
        @(negedge clk);
        chk("R9 R10 irq after clear", {7'd0, irq_drive}, 8'd0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
            $finish;
        end
    end
endmodule